// File: doc/BRIEF.md
# Serial Interrupt Bus Peripheral Agent

This block is the peripheral end of a single-wire serialized interrupt bus clocked by the PCI clock. Local logic gives it a set of interrupt request levels and a system-management request. The block follows the shared open-drain line through each bus cycle: a Start Frame, then a chain of three-clock data frames, then a Stop Frame. In every data frame whose request is active it pulls the line low for one clock and then drives it high for one clock before releasing it.

The width of the Stop Frame sets the mode of the next cycle. A two-clock Stop Frame selects Quiet mode. In that mode the agent may open a cycle itself by pulling the line low for one clock when it has something to report, and the host then stretches that pulse. A Stop Frame of three or more clocks selects Continuous mode, where only the host opens cycles. The third data frame is shared: a configuration bit assigns it either to interrupt 2 or to the management request, and the management request reaches the line only when its serial enable is also set.

Top module: `sirq_agent`

## Requirements
- R1: While `rst` is high `sirq_oe` is 0. After reset the agent is in Continuous mode and starts no cycle on its own, even with requests pending, until it has seen a two-clock Stop Frame.
- R2: Data frames are numbered from 0. Frame 0 begins in the first clock after the clock in which the line is sampled high following a Start Frame, and each frame lasts 3 clocks. Frame s carries `irq_req[s]` for every s below IRQ_W except 2. Frames IRQ_W through NUM_FRAMES-1 are never driven.
- R3: In a frame whose bit is 1 the agent drives low (`sirq_oe`=1, `sirq_out`=0) in the first clock and high (`sirq_oe`=1, `sirq_out`=1) in the second clock, and releases (`sirq_oe`=0) in the third. In a frame whose bit is 0, `sirq_oe` stays 0 in all three clocks.
- R4: Frame 2 carries `irq_req[2]` when `slot2_smi_sel`=0. When `slot2_smi_sel`=1 it carries `smi_req & smi_serial_en`.
- R5: Frame 13 carries `irq_req[13]`.
- R6: After its last frame, a Stop Frame of exactly 2 low clocks puts the agent in Quiet mode. A Stop Frame of 3 or more low clocks puts it in Continuous mode.
- R7: In Quiet mode with at least one frame bit at 1, the agent drives low in the third clock after the clock in which it sampled the Stop Frame's rising edge, and not earlier. It drives low for exactly one clock and then releases the line.
- R8: In Continuous mode the agent never drives the line outside its data frames.
- R9: Between its last frame and the end of the Stop Frame the agent leaves the line released, and a single-clock low pulse (another agent's frame) does not end the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock; every sample and drive happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sirq_in | input | 1 | Sampled level of the shared line |
| sirq_oe | output | 1 | 1 when the agent drives the line |
| sirq_out | output | 1 | Level driven while `sirq_oe` is 1 |
| irq_req | input | IRQ_W | Interrupt request levels, bit s for frame s |
| smi_req | input | 1 | System-management request |
| slot2_smi_sel | input | 1 | 1 assigns frame 2 to the management request |
| smi_serial_en | input | 1 | Lets the management request reach frame 2 |

## Verification
The checker watches on every clock the rules that concern the output pair alone: the line is released in reset, a low drive never lasts two clocks, a high drive always follows a low drive and is always followed by a release, and a self-started low comes only from Quiet mode after at least two idle clocks. The bench has to show the rest. That covers which request lands in which frame, the choice for frame 2, how Stop Frames of 2, 3 and 4 clocks are classified, and the exact clock of a Quiet-mode start. These need a host model that counts clocks against the expected frame contents.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_WAIT_STOP
    } sirq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOV,
        PH_TURN
    } sirq_phase_e;

    typedef enum logic {
        MODE_CONT,
        MODE_QUIET
    } sirq_mode_e;

    // frame shared between interrupt 2 and the management request
    localparam int SHARED_SLOT = 2;

    // low samples that end a cycle in Quiet mode; more selects Continuous
    localparam int QUIET_STOP_LEN = 2;

    function automatic sirq_mode_e mode_from_stop(input logic [1:0] low_cnt);
        return (low_cnt == 2'(QUIET_STOP_LEN)) ? MODE_QUIET : MODE_CONT;
    endfunction

endpackage

// File: rtl/sirq_frame_map.sv
module sirq_frame_map #(
    parameter int IRQ_W      = 16,
    parameter int NUM_FRAMES = 17
) (
    input  logic [IRQ_W-1:0]      irq_req,
    input  logic                  smi_req,
    input  logic                  slot2_smi_sel,
    input  logic                  smi_serial_en,
    output logic [NUM_FRAMES-1:0] frame_bits
);
    import sirq_pkg::*;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_slot
        if (g == SHARED_SLOT) begin : g_shared
            assign frame_bits[g] = slot2_smi_sel ? (smi_req & smi_serial_en)
                                                 : irq_req[g];
        end else if (g < IRQ_W) begin : g_irq
            assign frame_bits[g] = irq_req[g];
        end else begin : g_empty
            assign frame_bits[g] = 1'b0;
        end
    end

endmodule

// File: rtl/sirq_stop_meter.sv
module sirq_stop_meter (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_in,
    output logic                 stop_done,
    output sirq_pkg::sirq_mode_e stop_mode
);
    import sirq_pkg::*;

    // consecutive low samples, saturating at 3
    logic [1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= 2'd0;
        end else if (!line_in) begin
            if (low_cnt != 2'd3) low_cnt <= low_cnt + 2'd1;
        end else begin
            low_cnt <= 2'd0;
        end
    end

    assign stop_done = line_in && (low_cnt >= 2'(QUIET_STOP_LEN));
    assign stop_mode = mode_from_stop(low_cnt);

endmodule

// File: rtl/sirq_seq.sv
module sirq_seq #(
    parameter int NUM_FRAMES = 17
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_in,
    input  logic [NUM_FRAMES-1:0] frame_bits,
    input  logic                  stop_done,
    input  sirq_pkg::sirq_mode_e  stop_mode,
    output logic                  drv_oe,
    output logic                  drv_out,
    output sirq_pkg::sirq_state_e state_o,
    output sirq_pkg::sirq_mode_e  mode_o
);
    import sirq_pkg::*;

    localparam int SLOT_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_FRAMES - 1);

    sirq_state_e       state;
    sirq_phase_e       phase;
    sirq_mode_e        mode;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] next_slot;
    logic              cur_bit;
    logic              gap;
    logic              pending;

    assign next_slot = slot + 1'b1;
    assign pending   = |frame_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_SAMPLE;
            mode    <= MODE_CONT;
            slot    <= '0;
            cur_bit <= 1'b0;
            gap     <= 1'b0;
            drv_oe  <= 1'b0;
            drv_out <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    drv_oe <= 1'b0;
                    gap    <= 1'b0;
                    if (!line_in) begin
                        state <= ST_START;
                    end else if (mode == MODE_QUIET && !gap && pending) begin
                        drv_oe  <= 1'b1;
                        drv_out <= 1'b0;
                        state   <= ST_START;
                    end
                end
                ST_START: begin
                    drv_oe <= 1'b0;
                    if (line_in) begin
                        state   <= ST_DATA;
                        phase   <= PH_SAMPLE;
                        slot    <= '0;
                        cur_bit <= frame_bits[0];
                        drv_oe  <= frame_bits[0];
                        drv_out <= 1'b0;
                    end
                end
                ST_DATA: begin
                    case (phase)
                        PH_SAMPLE: begin
                            phase   <= PH_RECOV;
                            drv_oe  <= cur_bit;
                            drv_out <= 1'b1;
                        end
                        PH_RECOV: begin
                            phase  <= PH_TURN;
                            drv_oe <= 1'b0;
                        end
                        default: begin
                            if (slot == LAST_SLOT) begin
                                state  <= ST_WAIT_STOP;
                                drv_oe <= 1'b0;
                            end else begin
                                slot    <= next_slot;
                                phase   <= PH_SAMPLE;
                                cur_bit <= frame_bits[next_slot];
                                drv_oe  <= frame_bits[next_slot];
                                drv_out <= 1'b0;
                            end
                        end
                    endcase
                end
                default: begin
                    drv_oe <= 1'b0;
                    if (stop_done) begin
                        state <= ST_IDLE;
                        mode  <= stop_mode;
                        gap   <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign state_o = state;
    assign mode_o  = mode;

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent #(
    parameter int IRQ_W      = 16,
    parameter int NUM_FRAMES = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sirq_in,
    output logic             sirq_oe,
    output logic             sirq_out,
    input  logic [IRQ_W-1:0] irq_req,
    input  logic             smi_req,
    input  logic             slot2_smi_sel,
    input  logic             smi_serial_en
);
    import sirq_pkg::*;

    logic [NUM_FRAMES-1:0] frame_bits;
    logic                  stop_done;
    sirq_mode_e            stop_mode;
    sirq_state_e           state_w;
    sirq_mode_e            mode_w;

    sirq_frame_map #(
        .IRQ_W      (IRQ_W),
        .NUM_FRAMES (NUM_FRAMES)
    ) u_map (
        .irq_req       (irq_req),
        .smi_req       (smi_req),
        .slot2_smi_sel (slot2_smi_sel),
        .smi_serial_en (smi_serial_en),
        .frame_bits    (frame_bits)
    );

    sirq_stop_meter u_stop (
        .clk       (clk),
        .rst       (rst),
        .line_in   (sirq_in),
        .stop_done (stop_done),
        .stop_mode (stop_mode)
    );

    sirq_seq #(
        .NUM_FRAMES (NUM_FRAMES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .line_in    (sirq_in),
        .frame_bits (frame_bits),
        .stop_done  (stop_done),
        .stop_mode  (stop_mode),
        .drv_oe     (sirq_oe),
        .drv_out    (sirq_out),
        .state_o    (state_w),
        .mode_o     (mode_w)
    );

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk (
    input logic                  clk,
    input logic                  rst,
    input logic                  sirq_oe,
    input logic                  sirq_out,
    input sirq_pkg::sirq_state_e state,
    input sirq_pkg::sirq_mode_e  mode
);
    import sirq_pkg::*;

    AST_RST_RELEASE: assert property (@(posedge clk)
        rst |=> !sirq_oe); // R1

    AST_LOW_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (sirq_oe && !sirq_out) |=> !(sirq_oe && !sirq_out)); // R3

    AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        (sirq_oe && sirq_out) |-> $past(sirq_oe && !sirq_out)); // R3

    AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sirq_oe && sirq_out) |=> !sirq_oe); // R3

    AST_START_ONLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sirq_oe && !sirq_out && $past(state) == ST_IDLE)
            |-> $past(mode) == MODE_QUIET); // R8

    AST_START_GAP: assert property (@(posedge clk) disable iff (rst)
        (sirq_oe && !sirq_out && $past(state) == ST_IDLE)
            |-> $past(state, 2) == ST_IDLE); // R7

endmodule

bind sirq_agent sirq_agent_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sirq_oe  (sirq_oe),
    .sirq_out (sirq_out),
    .state    (state_w),
    .mode     (mode_w)
);

// File: tb/test_sirq_agent.sv
module test_sirq_agent;

    localparam int IRQ_W      = 16;
    localparam int NUM_FRAMES = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             host_low = 1'b0;
    logic             sirq_in;
    logic             sirq_oe;
    logic             sirq_out;
    logic [IRQ_W-1:0] irq_req = '0;
    logic             smi_req = 1'b0;
    logic             slot2_smi_sel = 1'b0;
    logic             smi_serial_en = 1'b0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  quiet    = 1'b0;

    always #2.5 clk = ~clk;

    // wired-AND line: low when the host or the agent pulls it down
    assign sirq_in = !(host_low || (sirq_oe && !sirq_out));

    sirq_agent #(
        .IRQ_W      (IRQ_W),
        .NUM_FRAMES (NUM_FRAMES)
    ) i_sirq_agent (
        .clk           (clk),
        .rst           (rst),
        .sirq_in       (sirq_in),
        .sirq_oe       (sirq_oe),
        .sirq_out      (sirq_out),
        .irq_req       (irq_req),
        .smi_req       (smi_req),
        .slot2_smi_sel (slot2_smi_sel),
        .smi_serial_en (smi_serial_en)
    );

    // line drive code: 0 released, 2 driven low, 3 driven high
    function automatic int drive_code();
        return sirq_oe ? (sirq_out ? 3 : 2) : 0;
    endfunction

    function automatic bit exp_bit(input int s);
        if (s == 2) return slot2_smi_sel ? (smi_req && smi_serial_en) : irq_req[2];
        if (s < IRQ_W) return irq_req[s];
        return 1'b0;
    endfunction

    function automatic bit any_pending();
        for (int s = 0; s < NUM_FRAMES; s++) if (exp_bit(s)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_start(input int len);
        host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic check_frames();
        for (int s = 0; s < NUM_FRAMES; s++) begin
            for (int ph = 0; ph < 3; ph++) begin
                string tag;
                int    e;
                @(negedge clk);
                tag = (s == 2) ? "R4" : (s == 13) ? "R5" : (s >= IRQ_W) ? "R2" : "R3";
                e = !exp_bit(s) ? 0 : (ph == 0) ? 2 : (ph == 1) ? 3 : 0;
                chk(tag, drive_code(), e);
            end
        end
    endtask

    task automatic foreign_frame();
        host_low = 1'b1;
        @(negedge clk);
        chk("R9", drive_code(), 0);
        host_low = 1'b0;
        @(negedge clk);
        chk("R9", drive_code(), 0);
        @(negedge clk);
        chk("R9", drive_code(), 0);
    endtask

    task automatic host_stop(input int len);
        host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
        quiet = (len == 2);
    endtask

    task automatic set_inputs(input int it);
        case (it)
            0: begin irq_req = 16'h2004; smi_req = 1'b1; slot2_smi_sel = 1'b0; smi_serial_en = 1'b0; end
            1: begin irq_req = 16'hFFFF; smi_req = 1'b0; slot2_smi_sel = 1'b1; smi_serial_en = 1'b1; end
            2: begin irq_req = 16'h0000; smi_req = 1'b1; slot2_smi_sel = 1'b1; smi_serial_en = 1'b0; end
            3: begin irq_req = 16'h0004; smi_req = 1'b1; slot2_smi_sel = 1'b1; smi_serial_en = 1'b1; end
            4: begin irq_req = 16'h0000; smi_req = 1'b0; slot2_smi_sel = 1'b0; smi_serial_en = 1'b0; end
            default: begin
                irq_req       = 16'($urandom) & 16'($urandom);
                smi_req       = 1'($urandom);
                slot2_smi_sel = 1'($urandom);
                smi_serial_en = 1'($urandom);
            end
        endcase
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        irq_req = 16'h0101;
        repeat (4) begin
            @(negedge clk);
            chk("R1", drive_code(), 0);
        end
        rst = 1'b0;
        // Continuous after reset: pending requests, no self-start
        repeat (8) begin
            @(negedge clk);
            chk("R1", drive_code(), 0);
        end

        for (int it = 0; it < 40; it++) begin
            int stop_len;
            set_inputs(it);
            if (quiet && any_pending()) begin
                @(negedge clk);
                chk("R7", drive_code(), 0);
                @(negedge clk);
                chk("R7", drive_code(), 0);
                @(negedge clk);
                chk("R6/R7", drive_code(), 2);
                host_low = 1'b1;
                @(negedge clk);
                chk("R7", drive_code(), 0);
                repeat (3) @(negedge clk);
                host_low = 1'b0;
            end else begin
                repeat (6) begin
                    @(negedge clk);
                    chk(quiet ? "R7" : "R6/R8", drive_code(), 0);
                end
                host_start(4 + int'($urandom_range(0, 4)));
            end
            check_frames();
            if (it % 3 == 1) foreign_frame();
            stop_len = (it < 6) ? ((it % 2 == 0) ? 2 : 3) : int'($urandom_range(2, 4));
            host_stop(stop_len);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule